// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This block builds an instrument's eight-bit status byte from four condition inputs: three event-register summaries and an output-queue-not-empty flag. It combines that byte with a stored enable mask and raises a service request line when an enabled condition appears. A bus controller reads the byte in one of two ways. A serial poll returns the byte with bit 6 reporting whether a request was pending, and it withdraws the request. A status query returns the byte with bit 6 reporting the current masked summary, and it leaves the request alone.

A request is edge-triggered. It is raised only when the masked summary goes from 0 to 1. A condition that stays active after a poll raises nothing further until it has gone away and come back.

Top module: `status_srq_unit`

## Requirements
- R1: Both returned bytes place the standard event summary on bit 5, the queue-has-data flag on bit 4, the first auxiliary summary on bit 1 and the second auxiliary summary on bit 0. Bits 7, 3 and 2 always read 0.
- R2: A cycle with `en_we` high loads `en_wdata` into the enable mask, which takes effect from the next cycle. Reset clears the mask to 0.
- R3: The master summary is the OR of status bits 5, 4, 1 and 0, each ANDed with the matching enable bit. Enable bits 7, 6, 3 and 2 have no effect.
- R4: A `query_stb` cycle captures the status byte with bit 6 equal to the live master summary. The capture appears on `query_byte` in the next cycle and holds until the next query. A query never changes `srq`.
- R5: A master summary that is 1 in a cycle after being 0 in the previous cycle sets the pending request. `srq` rises in the following cycle.
- R6: A `poll_stb` cycle captures the status byte with bit 6 equal to `srq` in that cycle and shows it on `poll_byte` next cycle. It clears `srq` unless a new rise of the master summary happens in the same cycle, in which case `srq` is 1 afterwards.
- R7: While the master summary stays 1 after a poll, `srq` stays 0. A new request needs the summary to fall to 0 and rise again.
- R8: Once set, `srq` stays 1 through queries, input changes and summary falls until a serial poll or a reset.
- R9: Reset drives `poll_byte`, `query_byte` and `srq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sum | input | 1 | Standard event register summary (status bit 5) |
| queue_avail | input | 1 | Output queue holds data (status bit 4) |
| aux1_sum | input | 1 | First auxiliary event summary (status bit 1) |
| aux0_sum | input | 1 | Second auxiliary event summary (status bit 0) |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write value |
| poll_stb | input | 1 | Serial poll strobe, one cycle |
| query_stb | input | 1 | Status query strobe, one cycle |
| poll_byte | output | 8 | Byte captured by the last serial poll |
| query_byte | output | 8 | Byte captured by the last status query |
| srq | output | 1 | Service request line |

## Verification
The assertions assume that every input is synchronous to `clk` and that each strobe is a single-cycle pulse. They also assume that a strobe arriving together with an input change refers to the inputs of that same cycle. The bench changes inputs and strobes only on the falling edge and releases each strobe after one cycle, so every value it sends is stable across the rising edge. The bench sweeps all 256 enable masks against all 16 condition patterns. Directed sequences then cover the held-summary, same-cycle rise-and-poll and mid-run reset cases.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int SB_W     = 8;
    localparam int POS_STD  = 5;
    localparam int POS_MAV  = 4;
    localparam int POS_AUX1 = 1;
    localparam int POS_AUX0 = 0;
    localparam int POS_MSS  = 6;
    localparam logic [SB_W-1:0] COND_BITS =
        SB_W'((1 << POS_STD) | (1 << POS_MAV) | (1 << POS_AUX1) | (1 << POS_AUX0));

    typedef struct packed {
        logic [SB_W-1:0] en;
    } mask_state_t;

    typedef struct packed {
        logic rqs;
        logic mss_prev;
    } pend_state_t;

    typedef struct packed {
        logic [SB_W-1:0] poll_byte;
        logic [SB_W-1:0] query_byte;
    } cap_state_t;
endpackage

// File: rtl/srq_mask_reg.sv
module srq_mask_reg
    import srq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SB_W-1:0] wdata,
    output logic [SB_W-1:0] mask
);
    mask_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.en = wdata & COND_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask = s_q.en;
endmodule

// File: rtl/srq_summary.sv
module srq_summary
    import srq_pkg::*;
(
    input  logic            std_sum,
    input  logic            queue_avail,
    input  logic            aux1_sum,
    input  logic            aux0_sum,
    input  logic [SB_W-1:0] mask,
    output logic [SB_W-1:0] cond,
    output logic            mss
);
    always_comb begin
        cond           = '0;
        cond[POS_STD]  = std_sum;
        cond[POS_MAV]  = queue_avail;
        cond[POS_AUX1] = aux1_sum;
        cond[POS_AUX0] = aux0_sum;
        mss            = |(cond & mask & COND_BITS);
    end
endmodule

// File: rtl/srq_pending.sv
module srq_pending
    import srq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss,
    input  logic poll,
    output logic rise,
    output logic rqs
);
    pend_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        rise         = mss & ~s_q.mss_prev;
        s_d.mss_prev = mss;
        s_d.rqs      = (s_q.rqs & ~poll) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rqs = s_q.rqs;
endmodule

// File: rtl/status_srq_unit.sv
module status_srq_unit
    import srq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            std_sum,
    input  logic            queue_avail,
    input  logic            aux1_sum,
    input  logic            aux0_sum,
    input  logic            en_we,
    input  logic [SB_W-1:0] en_wdata,
    input  logic            poll_stb,
    input  logic            query_stb,
    output logic [SB_W-1:0] poll_byte,
    output logic [SB_W-1:0] query_byte,
    output logic            srq
);
    logic [SB_W-1:0] mask_w;
    logic [SB_W-1:0] cond_w;
    logic            mss_w;
    logic            rise_w;
    logic            rqs_w;
    cap_state_t      s_d, s_q;

    srq_mask_reg i_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (en_we),
        .wdata (en_wdata),
        .mask  (mask_w)
    );

    srq_summary i_sum (
        .std_sum     (std_sum),
        .queue_avail (queue_avail),
        .aux1_sum    (aux1_sum),
        .aux0_sum    (aux0_sum),
        .mask        (mask_w),
        .cond        (cond_w),
        .mss         (mss_w)
    );

    srq_pending i_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .mss   (mss_w),
        .poll  (poll_stb),
        .rise  (rise_w),
        .rqs   (rqs_w)
    );

    always_comb begin
        s_d = s_q;
        if (poll_stb) begin
            s_d.poll_byte          = cond_w;
            s_d.poll_byte[POS_MSS] = rqs_w;
        end
        if (query_stb) begin
            s_d.query_byte          = cond_w;
            s_d.query_byte[POS_MSS] = mss_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign poll_byte  = s_q.poll_byte;
    assign query_byte = s_q.query_byte;
    assign srq        = rqs_w;
endmodule

// File: rtl/srq_checker.sv
module srq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_stb,
    input logic       query_stb,
    input logic [7:0] poll_byte,
    input logic [7:0] query_byte,
    input logic       srq,
    input logic       mss,
    input logic       rise
);
    p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((poll_byte & 8'h8C) == 8'h00) && ((query_byte & 8'h8C) == 8'h00));

    p_query_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        query_stb |=> query_byte[6] == $past(mss));

    p_query_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !query_stb |=> $stable(query_byte));

    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> srq);

    p_poll_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
        poll_stb |=> poll_byte[6] == $past(srq));

    p_poll_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb && !rise) |=> !srq);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srq) |-> $past(rise));

    p_srq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !poll_stb) |=> srq);
endmodule

bind status_srq_unit srq_checker i_srq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_stb   (poll_stb),
    .query_stb  (query_stb),
    .poll_byte  (poll_byte),
    .query_byte (query_byte),
    .srq        (srq),
    .mss        (mss_w),
    .rise       (rise_w)
);

// File: tb/test_status_srq_unit.sv
module test_status_srq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_sum = 1'b0, queue_avail = 1'b0, aux1_sum = 1'b0, aux0_sum = 1'b0;
    logic       en_we = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       poll_stb = 1'b0, query_stb = 1'b0;
    logic [7:0] poll_byte, query_byte;
    logic       srq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    status_srq_unit i_status_srq_unit (
        .clk, .rst_n, .std_sum, .queue_avail, .aux1_sum, .aux0_sum,
        .en_we, .en_wdata, .poll_stb, .query_stb,
        .poll_byte, .query_byte, .srq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] cond_of(input logic [3:0] p);
        return {2'b00, p[3], p[2], 2'b00, p[1], p[0]};
    endfunction

    function automatic logic mss_of(input logic [3:0] p, input logic [7:0] m);
        return (p[3] & m[5]) | (p[2] & m[4]) | (p[1] & m[1]) | (p[0] & m[0]);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_pat(input logic [3:0] p);
        {std_sum, queue_avail, aux1_sum, aux0_sum} = p;
    endtask

    task automatic write_mask(input logic [7:0] m);
        en_we = 1'b1; en_wdata = m;
        step();
        en_we = 1'b0;
    endtask

    task automatic poll();
        poll_stb = 1'b1;
        step();
        poll_stb = 1'b0;
    endtask

    task automatic query();
        query_stb = 1'b1;
        step();
        query_stb = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R9 reset values
        chk("R9 poll_byte", poll_byte, 8'h00);
        chk("R9 query_byte", query_byte, 8'h00);
        chk("R9 srq", {7'd0, srq}, 8'h00);
        rst_n = 1'b1;
        step();
        // R2 mask cleared by reset: all conditions active, no summary
        set_pat(4'hF);
        step();
        query();
        chk("R2 reset mask query", query_byte, 8'h33);
        chk("R2 reset mask srq", {7'd0, srq}, 8'h00);

        // Sweep: all masks, all patterns (R1 R2 R3 R4 R5 R6)
        for (int m = 0; m < 256; m++) begin
            write_mask(8'(m));
            for (int p = 0; p < 16; p++) begin
                logic e;
                set_pat(4'h0);
                poll();
                set_pat(4'(p));
                e = mss_of(4'(p), 8'(m));
                step();
                chk("R5 srq after rise", {7'd0, srq}, {7'd0, e});
                query();
                chk("R4 R3 R1 query_byte", query_byte, cond_of(4'(p)) | {1'b0, e, 6'd0});
                chk("R4 srq unchanged by query", {7'd0, srq}, {7'd0, e});
                poll();
                chk("R6 R1 poll_byte", poll_byte, cond_of(4'(p)) | {1'b0, e, 6'd0});
                chk("R6 srq cleared", {7'd0, srq}, 8'h00);
            end
        end

        // R7: held summary raises nothing new
        set_pat(4'h0);
        write_mask(8'h10);
        poll();
        set_pat(4'b0100);
        step();
        chk("R7 first request", {7'd0, srq}, 8'h01);
        poll();
        repeat (4) step();
        chk("R7 no request while held", {7'd0, srq}, 8'h00);
        set_pat(4'h0);
        step();
        chk("R7 fall raises nothing", {7'd0, srq}, 8'h00);
        set_pat(4'b0100);
        step();
        chk("R7 re-rise requests", {7'd0, srq}, 8'h01);

        // R8: srq holds across queries and summary fall
        set_pat(4'h0);
        query();
        repeat (3) step();
        chk("R8 srq held", {7'd0, srq}, 8'h01);
        chk("R4 query_byte after fall", query_byte, 8'h00);
        set_pat(4'b1000);
        repeat (2) step();
        chk("R4 query_byte holds without strobe", query_byte, 8'h00);
        poll();
        chk("R8 R6 poll_byte shows pending", poll_byte, 8'h60);
        chk("R8 srq cleared by poll", {7'd0, srq}, 8'h00);

        // R6: rise in same cycle as poll keeps the request
        set_pat(4'h0);
        write_mask(8'h02);
        set_pat(4'b0010);
        poll();
        chk("R6 same-cycle poll_byte", poll_byte, 8'h02);
        chk("R6 same-cycle srq kept", {7'd0, srq}, 8'h01);

        // R3: bit 6 and unused enable bits have no effect
        set_pat(4'h0);
        poll();
        write_mask(8'hCC);
        set_pat(4'hF);
        step();
        chk("R3 unused enable bits", {7'd0, srq}, 8'h00);
        query();
        chk("R3 query bit6 low", query_byte, 8'h33);

        // R9 mid-run reset
        write_mask(8'h01);
        set_pat(4'h0);
        step();
        set_pat(4'h1);
        step();
        query();
        chk("R9 pre-reset srq", {7'd0, srq}, 8'h01);
        rst_n = 1'b0;
        step();
        chk("R9 reset srq", {7'd0, srq}, 8'h00);
        chk("R9 reset query_byte", query_byte, 8'h00);
        rst_n = 1'b1;
        step(); step();
        chk("R2 mask cleared by reset", {7'd0, srq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule